// File: doc/BRIEF.md
# Multi-format PCM serial receiver

This block turns a stereo serial audio stream into parallel samples. It watches a bit clock, a frame (word-select) clock and two candidate data lines. It samples all of them with a faster system clock, finds the rising bit-clock edges and the transitions of the frame clock, and cuts each half-frame into one sample according to a 2-bit framing format. Completed left/right pairs are presented as two 24-bit words together with a one-cycle valid strobe.

Four framings are supported. Two are right-aligned, with 16 or 24 bits ending at the word-select edge. One is left-aligned, with 24 bits starting at the edge. The last is I2S, with the MSB one bit clock after the edge, carrying 16 or 24 bits. A source selector picks which data line is decoded and flags the bypass routing. The framing selector is taken into the block only when a frame completes. Until the first frame has completed after reset, the block decodes I2S.

Top module: `pcm_serial_rx`

## Requirements
- R1: After reset `left_o` and `right_o` are zero and `valid_o` is low. The active framing is I2S, so the first pair completed after reset is decoded as I2S whatever `fmt_i` holds.
- R2: `fmt_i` is copied into the active framing in the clock cycle after each `valid_o` pulse, and it governs the half-frames that follow. Encoding: 0 = 16-bit right-aligned, 1 = 24-bit right-aligned, 2 = 24-bit left-aligned, 3 = I2S.
- R3: Format 0: the sample is the last 16 bits before the word-select edge, MSB first. It is delivered in bits 23:8 with bits 7:0 zero. This works at 32, 48 and 64 bit clocks per frame.
- R4: Format 1: the sample is the last 24 bits before the word-select edge, MSB first, at 48 or more bit clocks per frame.
- R5: Format 2: the sample is the first 24 bits after the word-select edge, MSB first, at 48 or more bit clocks per frame.
- R6: Format 3: the MSB is the second bit after the edge. A half-frame of 25 or more bits gives 24 bits. A shorter half-frame gives its remaining bits plus the first bit of the next half, left-aligned: 16 bits with zero fill at 32 clocks per frame, and 24 bits at 48.
- R7: In formats 0 to 2 the word-select-high half is left. In format 3 the word-select-low half is left.
- R8: Data bits outside the sample window have no effect on the delivered words.
- R9: `valid_o` is a one-cycle pulse, issued once for each right half that follows a captured left half. `left_o` and `right_o` change only together with that pulse.
- R10: Source select: 00 decodes `sdata1_i`, 01 and 10 decode `sdata2_i`, 11 decodes a constant zero line.
- R11: `bypass_o` is high exactly when the source select is 10.
- R12: The half-frame running when the first word-select transition after reset is seen is discarded. So is a right half with no left half before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck_i | input | 1 | Serial bit clock, data taken on its rising edge |
| lrck_i | input | 1 | Word-select (frame) clock |
| sdata1_i | input | 1 | Serial data line 1 |
| sdata2_i | input | 1 | Serial data line 2 |
| fmt_i | input | 2 | Requested framing format |
| src_sel_i | input | 2 | Data line select |
| left_o | output | 24 | Left sample, two's complement, left-aligned |
| right_o | output | 24 | Right sample, two's complement, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a completed pair |
| bypass_o | output | 1 | High when the bypass routing is selected |

## Verification
The word-select edge is the busiest event. At that single bit-clock rise, in I2S with a short half, the same data bit completes the previous word as its LSB and also opens the new half, whose first bit is discarded. The pair that this word completes then raises `valid_o`, and that pulse reloads the active format. The bench provokes both collisions by sweeping I2S at 32 and 48 bit clocks per frame, where the LSB lands on the boundary bit, and by switching `fmt_i` between segments. It judges the results only on pairs recorded after a few priming frames, against words it recomputes from the requirements.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int NARROW_W = 16;
  localparam int PAD_W    = SAMPLE_W - NARROW_W;
  localparam int CNT_W    = $clog2(SAMPLE_W + 1);

  typedef enum logic [1:0] {
    FMT_RJ16 = 2'd0,
    FMT_RJ24 = 2'd1,
    FMT_LJ24 = 2'd2,
    FMT_I2S  = 2'd3
  } fmt_e;

  // right-aligned word: tail of the history register, narrow words padded low
  function automatic logic [SAMPLE_W-1:0] tail_word(input logic [SAMPLE_W-1:0] hist,
                                                     input logic narrow);
    if (narrow) return {hist[NARROW_W-1:0], {PAD_W{1'b0}}};
    return hist;
  endfunction

  // delayed-MSB word: if the half was too short, the boundary bit is the LSB
  function automatic logic [SAMPLE_W-1:0] delayed_word(input logic [SAMPLE_W-1:0] acc,
                                                        input logic [CNT_W-1:0] n,
                                                        input logic edge_bit);
    logic [SAMPLE_W-1:0] t;
    if (n >= CNT_W'(SAMPLE_W)) return acc;
    t = {acc[SAMPLE_W-2:0], edge_bit};
    return t << (CNT_W'(SAMPLE_W - 1) - n);
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2,
  parameter int W      = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= '0;
      else        pipe[g] <= pipe[g-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/rx_slot_capture.sv
module rx_slot_capture
  import pcm_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  fmt_e                fmt_i,
  input  logic                bck_i,
  input  logic                lr_i,
  input  logic                dat_i,
  output logic                word_stb_o,
  output logic [SAMPLE_W-1:0] word_o,
  output logic                word_lr_o
);
  logic                bck_q;
  logic                lr_prev;
  logic                armed;
  logic [SAMPLE_W-1:0] hist;
  logic [SAMPLE_W-1:0] acc;
  logic [CNT_W-1:0]    acc_n;
  logic [SAMPLE_W-1:0] done_word;

  // named internal events
  logic bit_rise;
  logic half_edge;
  assign bit_rise  = bck_i & ~bck_q;
  assign half_edge = bit_rise & (lr_i != lr_prev);

  always_comb begin
    unique case (fmt_i)
      FMT_RJ16: done_word = tail_word(hist, 1'b1);
      FMT_RJ24: done_word = tail_word(hist, 1'b0);
      FMT_LJ24: done_word = acc;
      default:  done_word = delayed_word(acc, acc_n, dat_i);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q      <= 1'b0;
      lr_prev    <= 1'b0;
      armed      <= 1'b0;
      hist       <= '0;
      acc        <= '0;
      acc_n      <= '0;
      word_stb_o <= 1'b0;
      word_o     <= '0;
      word_lr_o  <= 1'b0;
    end else begin
      bck_q      <= bck_i;
      word_stb_o <= 1'b0;
      if (bit_rise) begin
        hist    <= {hist[SAMPLE_W-2:0], dat_i};
        lr_prev <= lr_i;
        if (half_edge) begin
          armed <= 1'b1;
          if (armed) begin
            word_stb_o <= 1'b1;
            word_o     <= done_word;
            word_lr_o  <= lr_prev;
          end
          if (fmt_i == FMT_LJ24) begin
            acc   <= {{(SAMPLE_W-1){1'b0}}, dat_i};
            acc_n <= CNT_W'(1);
          end else begin
            acc   <= '0;
            acc_n <= '0;
          end
        end else if (acc_n < CNT_W'(SAMPLE_W)) begin
          acc   <= {acc[SAMPLE_W-2:0], dat_i};
          acc_n <= acc_n + CNT_W'(1);
        end
      end
    end
  end

  // R9
  word_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb_o |-> $past(bit_rise));

  // R12
  word_after_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb_o |-> $past(armed));
endmodule

// File: rtl/rx_frame_pair.sv
module rx_frame_pair
  import pcm_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_stb_i,
  input  logic [SAMPLE_W-1:0] word_i,
  input  logic                is_left_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic                have_left;
  logic [SAMPLE_W-1:0] left_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_left <= 1'b0;
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (word_stb_i) begin
        if (is_left_i) begin
          left_hold <= word_i;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_o    <= left_hold;
          right_o   <= word_i;
          valid_o   <= 1'b1;
          have_left <= 1'b0;
        end
      end
    end
  end

  // R9
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R12
  valid_needs_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(have_left));

  // R9
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bck_i,
  input  logic                lrck_i,
  input  logic                sdata1_i,
  input  logic                sdata2_i,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          src_sel_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                bypass_o
);
  logic [3:0]          raw_in;
  logic [3:0]          syn;
  logic                dat_sel;
  fmt_e                fmt_act;
  logic                word_stb;
  logic [SAMPLE_W-1:0] word;
  logic                word_lr;
  logic                word_is_left;

  assign raw_in = {sdata2_i, sdata1_i, lrck_i, bck_i};

  rx_sync #(.STAGES(SYNC_STAGES), .W(4)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (syn)
  );

  always_comb begin
    unique case (src_sel_i)
      2'b00:   dat_sel = syn[2];
      2'b01,
      2'b10:   dat_sel = syn[3];
      default: dat_sel = 1'b0;
    endcase
  end

  assign bypass_o = (src_sel_i == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fmt_act <= FMT_I2S;
    else if (valid_o) fmt_act <= fmt_e'(fmt_i);
  end

  rx_slot_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_i      (fmt_act),
    .bck_i      (syn[0]),
    .lr_i       (syn[1]),
    .dat_i      (dat_sel),
    .word_stb_o (word_stb),
    .word_o     (word),
    .word_lr_o  (word_lr)
  );

  assign word_is_left = (fmt_act == FMT_I2S) ? ~word_lr : word_lr;

  rx_frame_pair u_pair (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_stb_i (word_stb),
    .word_i     (word),
    .is_left_i  (word_is_left),
    .left_o     (left_o),
    .right_o    (right_o),
    .valid_o    (valid_o)
  );

  // R2
  fmt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fmt_act) |-> $past(valid_o));

  // R3
  narrow_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && fmt_act == FMT_RJ16) |->
      (left_o[PAD_W-1:0] == '0 && right_o[PAD_W-1:0] == '0));
endmodule

// File: tb/tb_pcm_serial_rx.sv
module tb_pcm_serial_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bck_i = 1'b0;
  logic        lrck_i = 1'b0;
  logic        sdata1_i = 1'b0;
  logic        sdata2_i = 1'b0;
  logic [1:0]  fmt_i = 2'd0;
  logic [1:0]  src_sel_i = 2'd0;
  logic [23:0] left_o;
  logic [23:0] right_o;
  logic        valid_o;
  logic        bypass_o;

  int tests = 0;
  int fails = 0;
  int vcnt  = 0;
  bit done  = 0;
  bit cur_lr = 0;
  bit prev_lsb = 0;
  logic [23:0] got_l [512];
  logic [23:0] got_r [512];

  always #4 clk = ~clk;

  pcm_serial_rx dut (
    .clk(clk), .rst_n(rst_n), .bck_i(bck_i), .lrck_i(lrck_i),
    .sdata1_i(sdata1_i), .sdata2_i(sdata2_i), .fmt_i(fmt_i),
    .src_sel_i(src_sel_i), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o), .bypass_o(bypass_o)
  );

  always @(negedge clk) begin
    if (rst_n && valid_o && vcnt < 512) begin
      got_l[vcnt] = left_o;
      got_r[vcnt] = right_o;
      vcnt++;
    end
  end

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit enc_bit(int m, int h, int i, logic [23:0] s, bit pl);
    bit junk;
    junk = ((i % 3) == 1);
    case (m)
      0: if (i >= h - 16) return s[8 + h - 1 - i];
      1: if (i >= h - 24) return s[h - 1 - i];
      2: if (i < 24) return s[23 - i];
      default: begin
        if (i == 0 && h < 25) return pl;
        if (i >= 1 && i <= 24) return s[24 - i];
      end
    endcase
    return junk;
  endfunction

  function automatic logic [23:0] exp_word(int m, int h, logic [23:0] s);
    if (m == 0 || (m == 3 && h == 16)) return {s[23:8], 8'h00};
    return s;
  endfunction

  task automatic send_half(input bit lv, input logic [23:0] s, input int m, input int h);
    for (int i = 0; i < h; i++) begin
      bit b;
      @(negedge clk);
      bck_i = 1'b0;
      lrck_i = lv;
      b = enc_bit(m, h, i, s, prev_lsb);
      sdata1_i = b;
      sdata2_i = ~b;
      repeat (3) @(negedge clk);
      bck_i = 1'b1;
      repeat (4) @(negedge clk);
    end
    prev_lsb = (h < 25) ? s[24 - h] : 1'b0;
    cur_lr = lv;
  endtask

  task automatic send_frame(input int m, input int h, input logic [23:0] l, input logic [23:0] r);
    bit lv;
    lv = (m == 3) ? 1'b0 : 1'b1;
    if (cur_lr == lv) send_half(~lv, 24'h0, m, h);
    send_half(lv, l, m, h);
    send_half(~lv, r, m, h);
  endtask

  // kind: 0 plain line 1, 1 inverted line 2, 2 zero line
  task automatic run_seg(input int m, input int h, input logic [1:0] sel,
                         input int kind, input string tag);
    logic [23:0] ls [3];
    logic [23:0] rs [3];
    fmt_i = 2'(m);
    src_sel_i = sel;
    for (int p = 0; p < 3; p++) send_frame(m, h, 24'h0F0F0F ^ 24'(p), 24'hF0F0F0);
    for (int k = 0; k < 3; k++) begin
      ls[k] = 24'hA5C3E1 + 24'(k) * 24'h13579B + 24'(m) * 24'h2468AC + 24'(h);
      rs[k] = ~ls[k] ^ (24'(k) << 4) ^ 24'h800001;
      send_frame(m, h, ls[k], rs[k]);
    end
    send_half(~cur_lr, 24'h0, m, h);
    repeat (40) @(negedge clk);
    tests++;
    if (vcnt < 3) begin
      fails++;
      $display("FAIL %s R9 pairs actual=%0d expected>=3", tag, vcnt);
    end else begin
      for (int k = 0; k < 3; k++) begin
        logic [23:0] el, er;
        el = (kind == 2) ? 24'h0 : exp_word(m, h, (kind == 1) ? ~ls[k] : ls[k]);
        er = (kind == 2) ? 24'h0 : exp_word(m, h, (kind == 1) ? ~rs[k] : rs[k]);
        chk({tag, " left"},  got_l[vcnt - 3 + k], el);
        chk({tag, " right"}, got_r[vcnt - 3 + k], er);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 left reset", left_o, 24'h0);
    chk("R1 right reset", right_o, 24'h0);
    chk("R1 valid reset", {23'h0, valid_o}, 24'h0);
    chk("R11 bypass sel00", {23'h0, bypass_o}, 24'h0);
    // R1 R12: I2S stream while fmt_i asks for format 0; lead half is discarded
    fmt_i = 2'd0;
    send_frame(3, 32, 24'h7B2D19, 24'h84C3A6);
    send_half(~cur_lr, 24'h0, 3, 32);
    repeat (40) @(negedge clk);
    chk("R12 one pair after reset", 24'(vcnt), 24'd1);
    chk("R1 first left as I2S", got_l[0], 24'h7B2D19);
    chk("R1 first right as I2S", got_r[0], 24'h84C3A6);
    // R2 format now taken from fmt_i; R3 R7 R8 sweeps
    run_seg(0, 32, 2'b00, 0, "R2 R3 m0 64fs");
    run_seg(0, 24, 2'b00, 0, "R3 R8 m0 48fs");
    run_seg(0, 16, 2'b00, 0, "R3 m0 32fs");
    run_seg(1, 32, 2'b00, 0, "R4 R8 m1 64fs");
    run_seg(1, 24, 2'b00, 0, "R4 m1 48fs");
    run_seg(2, 32, 2'b00, 0, "R5 R8 m2 64fs");
    run_seg(2, 24, 2'b00, 0, "R5 m2 48fs");
    run_seg(3, 32, 2'b00, 0, "R6 R7 m3 64fs");
    run_seg(3, 24, 2'b00, 0, "R6 m3 48fs");
    run_seg(3, 16, 2'b00, 0, "R6 m3 32fs");
    run_seg(0, 32, 2'b00, 0, "R2 R7 back to m0");
    // R10 R11 source select
    run_seg(1, 32, 2'b01, 1, "R10 sel01");
    chk("R11 bypass sel01", {23'h0, bypass_o}, 24'h0);
    run_seg(1, 32, 2'b10, 1, "R10 sel10");
    chk("R11 bypass sel10", {23'h0, bypass_o}, 24'h1);
    run_seg(1, 32, 2'b11, 2, "R10 sel11 zero");
    chk("R11 bypass sel11", {23'h0, bypass_o}, 24'h0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule